// File: doc/BRIEF.md
# Six-Entry Return Stack

This block is a small hardware stack of 16-bit words that holds return addresses for a processor's call and return flow. Software reaches it as one register. Writing the register pushes a word, and reading it pops a word. The current depth is visible on a pointer output.

The stack never stalls and never saturates. When software pushes onto a full stack, or pops an empty one, the pointer wraps to a defined position and the operation still completes. A one-cycle overflow or underflow event pulse reports the misuse, so that a supervisor can react to it.

A pop returns its word in the same cycle as the strobe, as a register read would. The pointer and the event outputs change at the clock edge that ends that cycle.

Top module: `rstk_top`

## Requirements
- R1: An active-high synchronous reset sets the depth to 0 and clears both event outputs and all six entries to zero.
- R2: A push with the depth below 6 writes `push_data_i` into entry number depth, and depth then rises by one at the clock edge.
- R3: A pop with the depth above 0 drives `pop_data_o`, in the same cycle, with the entry at index depth minus one. Depth falls to that index at the clock edge.
- R4: A push at depth 6 writes entry 0, leaves depth 1 after the edge, and raises `overflow_o` for the one cycle after the strobe.
- R5: A pop at depth 0 returns entry 5, leaves depth 5 after the edge, and raises `underflow_o` for the one cycle after the strobe.
- R6: Each event output is high for exactly one cycle per wrap, and the two are never high together.
- R7: When push and pop are strobed in the same cycle, the pop is performed and the push is ignored, so no entry is written.
- R8: While `pop_i` is low, `pop_data_o` is zero.
- R9: An overflow push overwrites only entry 0, and entries 1 to 5 keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop strobe |
| pop_data_o | output | 16 | Popped word, valid while pop_i is high |
| depth_o | output | 3 | Current stack pointer, 0 to 6 |
| overflow_o | output | 1 | One-cycle pulse after a push onto a full stack |
| underflow_o | output | 1 | One-cycle pulse after a pop from an empty stack |

## Verification
The stack is filled with distinct words in an interleaved push and pop order. Because every value differs, any indexing slip shows up as a wrong word rather than a coincidental match.

A push onto the full stack and a later pop past empty check both wrap paths. The pop past empty then reads entry 5, which shows that the overflow write landed only in entry 0.

A simultaneous push and pop is issued where the ignored push would land in entry 5. The final underflow pop reads that entry back, so an unwanted write cannot hide.

A reset in the middle of the run, followed by an underflow pop, shows that the entries were cleared.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    localparam int RSTK_DATA_W = 16;
    localparam int RSTK_DEPTH  = 6;

    typedef enum logic [1:0] {
        RSTK_IDLE = 2'd0,
        RSTK_PUSH = 2'd1,
        RSTK_POP  = 2'd2
    } rstk_op_e;

    // Pop wins over push when both strobes are high.
    function automatic rstk_op_e rstk_decode(input logic push, input logic pop);
        if (pop)       return RSTK_POP;
        else if (push) return RSTK_PUSH;
        else           return RSTK_IDLE;
    endfunction

endpackage

// File: rtl/rstk_ptr_ctrl.sv
module rstk_ptr_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = RSTK_DEPTH,
    parameter int PTR_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic [PTR_W-1:0] ptr_o,
    output logic             ovf_o,
    output logic             unf_o
);

    localparam logic [PTR_W-1:0] FULL_P = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE_P  = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             ovf;
        logic             unf;
    } state_t;

    state_t   st_d, st_q;
    rstk_op_e op;

    always_comb begin
        op       = rstk_decode(push_i, pop_i);
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        wr_en_o  = 1'b0;
        wr_idx_o = st_q.ptr;
        rd_idx_o = '0;
        unique case (op)
            RSTK_PUSH: begin
                wr_en_o = 1'b1;
                if (st_q.ptr >= FULL_P) begin
                    wr_idx_o = '0;
                    st_d.ptr = ONE_P;
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.ptr = st_q.ptr + ONE_P;
                end
            end
            RSTK_POP: begin
                if (st_q.ptr == '0) begin
                    rd_idx_o = LAST_P;
                    st_d.ptr = LAST_P;
                    st_d.unf = 1'b1;
                end else begin
                    rd_idx_o = st_q.ptr - ONE_P;
                    st_d.ptr = st_q.ptr - ONE_P;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ptr_o = st_q.ptr;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        st_q.ptr <= FULL_P); // R2
    AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && st_q.ptr < FULL_P) |=> st_q.ptr == PTR_W'($past(st_q.ptr) + ONE_P)); // R2
    AST_POP_RETREAT: assert property (@(posedge clk) disable iff (rst)
        (pop_i && st_q.ptr != '0) |=> st_q.ptr == PTR_W'($past(st_q.ptr) - ONE_P)); // R3
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && st_q.ptr >= FULL_P) |=> (st_q.ptr == ONE_P && ovf_o)); // R4
    AST_UNF_WRAP: assert property (@(posedge clk) disable iff (rst)
        (pop_i && st_q.ptr == '0) |=> (st_q.ptr == LAST_P && unf_o)); // R5
    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o)); // R6
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> !ovf_o); // R6
    AST_UNF_PULSE: assert property (@(posedge clk) disable iff (rst)
        unf_o |=> !unf_o); // R6
    AST_POP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i) |-> !wr_en_o); // R7

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 16,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] ent_q [DEPTH];
    logic [DATA_W-1:0] ent_d [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en_i && wr_idx_i == PTR_W'(g)) ent_d[g] = wr_data_i;
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q[g] <= '0;
            else     ent_q[g] <= ent_d[g];
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == PTR_W'(i)) rd_data_o = ent_q[i];
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> wr_idx_i < PTR_W'(DEPTH)); // R9

endmodule

// File: rtl/rstk_top.sv
module rstk_top
    import rstk_pkg::*;
#(
    parameter int DEPTH  = RSTK_DEPTH,
    parameter int DATA_W = RSTK_DATA_W,
    parameter int PTR_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic [PTR_W-1:0]  depth_o,
    output logic              overflow_o,
    output logic              underflow_o
);

    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [PTR_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    rstk_ptr_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W)
    ) i_ptr (
        .clk      (clk),
        .rst      (rst),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .ptr_o    (depth_o),
        .ovf_o    (overflow_o),
        .unf_o    (underflow_o)
    );

    rstk_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) i_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_data_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (rd_data)
    );

    assign pop_data_o = pop_i ? rd_data : '0;

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (depth_o == '0 && !overflow_o && !underflow_o)); // R1

endmodule

// File: tb/test_rstk_top.sv
`timescale 1ns/1ps
module test_rstk_top;

    localparam int  DW     = 16;
    localparam int  PW     = 3;
    localparam int  NV     = 18;
    localparam real HALF   = 2.5;
    localparam int  VEC_W  = 1 + 1 + DW + DW + PW + 1 + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          push_i = 1'b0;
    logic [DW-1:0] push_data_i = '0;
    logic          pop_i = 1'b0;
    logic [DW-1:0] pop_data_o;
    logic [PW-1:0] depth_o;
    logic          overflow_o;
    logic          underflow_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(HALF) clk = ~clk;

    rstk_top i_rstk_top (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .push_data_i (push_data_i),
        .pop_i       (pop_i),
        .pop_data_o  (pop_data_o),
        .depth_o     (depth_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    function automatic logic [VEC_W-1:0] vec(input logic pu, input logic po,
                                             input logic [DW-1:0] din,
                                             input logic [DW-1:0] exp_rd,
                                             input logic [PW-1:0] exp_dep,
                                             input logic eo, input logic eu);
        return {pu, po, din, exp_rd, exp_dep, eo, eu};
    endfunction

    // push, pop, data, expected pop data (same cycle), depth / ovf / unf after edge
    localparam logic [VEC_W-1:0] VECS [NV] = '{
        vec(1, 0, 16'h1101, 16'h0000, 3'd1, 0, 0),  // R2
        vec(1, 0, 16'h2202, 16'h0000, 3'd2, 0, 0),  // R2
        vec(0, 1, 16'h0000, 16'h2202, 3'd1, 0, 0),  // R3
        vec(1, 0, 16'h3303, 16'h0000, 3'd2, 0, 0),
        vec(1, 0, 16'h4404, 16'h0000, 3'd3, 0, 0),
        vec(1, 0, 16'h5505, 16'h0000, 3'd4, 0, 0),
        vec(1, 0, 16'h6606, 16'h0000, 3'd5, 0, 0),
        vec(1, 0, 16'h7707, 16'h0000, 3'd6, 0, 0),
        vec(1, 0, 16'h8808, 16'h0000, 3'd1, 1, 0),  // R4 overflow
        vec(0, 1, 16'h0000, 16'h8808, 3'd0, 0, 0),  // R6 pulse ends
        vec(0, 1, 16'h0000, 16'h7707, 3'd5, 0, 1),  // R5 underflow
        vec(1, 1, 16'hBEEF, 16'h6606, 3'd4, 0, 0),  // R7 pop wins
        vec(0, 1, 16'h0000, 16'h5505, 3'd3, 0, 0),  // R9
        vec(0, 1, 16'h0000, 16'h4404, 3'd2, 0, 0),  // R9
        vec(0, 1, 16'h0000, 16'h3303, 3'd1, 0, 0),  // R9
        vec(0, 1, 16'h0000, 16'h8808, 3'd0, 0, 0),
        vec(0, 1, 16'h0000, 16'h7707, 3'd5, 0, 1),  // R7 entry 5 not BEEF
        vec(0, 0, 16'h0000, 16'h0000, 3'd5, 0, 0)   // R8 idle data zero
    };

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "depth", 16'(depth_o), 16'd0);
        check("R1", "overflow", 16'(overflow_o), 16'd0);
        check("R1", "underflow", 16'(underflow_o), 16'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            logic [VEC_W-1:0] v;
            v = VECS[k];
            @(negedge clk);
            push_i      = v[VEC_W-1];
            pop_i       = v[VEC_W-2];
            push_data_i = v[VEC_W-3 -: DW];
            #1;
            check(v[VEC_W-2] ? "R3" : "R8", $sformatf("vec %0d pop data", k),
                  pop_data_o, v[VEC_W-3-DW -: DW]);
            @(posedge clk);
            #1;
            check("R2", $sformatf("vec %0d depth", k), 16'(depth_o), 16'(v[2 +: PW]));
            check("R4", $sformatf("vec %0d overflow", k), 16'(overflow_o), 16'(v[1]));
            check("R5", $sformatf("vec %0d underflow", k), 16'(underflow_o), 16'(v[0]));
        end

        // Reset mid-run clears pointer and entries (R1)
        @(negedge clk);
        push_i = 1'b0;
        pop_i  = 1'b0;
        rst    = 1'b1;
        @(posedge clk);
        #1;
        check("R1", "depth after reset", 16'(depth_o), 16'd0);
        @(negedge clk);
        rst   = 1'b0;
        pop_i = 1'b1;
        #1;
        check("R1", "entry 5 cleared", pop_data_o, 16'h0000);
        @(posedge clk);
        #1;
        check("R5", "underflow after reset", 16'(underflow_o), 16'd1);
        check("R5", "depth after wrap", 16'(depth_o), 16'd5);
        @(negedge clk);
        pop_i = 1'b0;
        @(posedge clk);
        #1;
        check("R6", "underflow single cycle", 16'(underflow_o), 16'd0);

        finish_run();
    end

endmodule